// File: doc/BRIEF.md
# Programmable Down-Counting Interrupt Timer

This block is one 32-bit timer channel reached over a plain register bus: a byte address, write data, a write strobe and registered read data. A counter decrements once per tick, and ticks come from the system clock divided by 1, 16 or 256. When the count steps from one to zero a sticky raw flag is raised. The interrupt line is that flag gated by an enable bit. Software removes the flag by writing anything to a clear register.

The counter has three behaviours. With neither mode bit set it wraps from zero to its maximum, so it runs freely. In periodic mode it reloads from the load register. In one-shot mode it parks at zero. Writing the load register presets the counter at once. Writing the value register presets the counter and leaves the load register unchanged. Because the count only goes down, software gets a rising timestamp by inverting what it reads. A size bit narrows the counter to 16 bits.

Top module: `dtimer_top`

## Requirements
- R1: After synchronous reset, every readable register, the read data and `irq_o` are zero.
- R2: A write to byte offset 0x00 stores the load register and in the same edge sets the counter to the written data, masked to the active size. The prescaler restarts at the same edge.
- R3: A write to byte offset 0x04 sets the counter directly and leaves the load register unchanged. A read at 0x04 returns the current count.
- R4: Control register bits [6:5] choose the tick rate. The encodings are 00 = clock/1, 01 = clock/16, 10 = clock/256 and 11 = clock/1. After enable is set at edge E, ticks fall on edges E+d, E+2d and so on.
- R5: With control bits [1] (periodic) and [2] (one-shot) both clear, a tick at count zero wraps the counter to its all-ones value.
- R6: With control bit [1] set and bit [2] clear, a tick at count zero reloads the counter from the load register.
- R7: With control bit [2] set, the counter stops at zero, and bit [2] takes precedence over bit [1]. A later write to the load register restarts the countdown.
- R8: The raw flag is read as bit 0 at offset 0x10. It sets on the edge of the tick that moves the count from 1 to 0.
- R9: A write of any data to offset 0x0C clears the raw flag. If the flag sets on the same edge, the set wins.
- R10: `irq_o` equals the raw flag ANDed with control bit [3] (interrupt enable). The same AND is readable as bit 0 at offset 0x14.
- R11: With control bit [4] clear, the counter is 16 bits wide. Written data is masked to the low 16 bits and the counter wraps to 0x0000FFFF. With bit [4] set, it is 32 bits wide.
- R12: With control bit [0] (enable) clear, the count holds its value except when it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Interrupt line, registered |

## Verification
The countdown is exercised under every prescaler setting with load values and run lengths picked so that the number of ticks falls exactly on, and just short of, a multiple of the divider; this separates an off-by-one prescaler from a correct one. The wrap, reload and stop modes are each driven through the zero crossing. The count read back afterwards tells all three apart, because the step after zero gives all ones, the load value or zero respectively. Clear and set are forced onto the same edge to show that the set wins. The 16-bit size is checked both by masking on write and by the wrap value.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  // word index of each register (byte offset >> 2)
  localparam logic [2:0] IDX_LOAD  = 3'd0;
  localparam logic [2:0] IDX_VALUE = 3'd1;
  localparam logic [2:0] IDX_CTRL  = 3'd2;
  localparam logic [2:0] IDX_CLEAR = 3'd3;
  localparam logic [2:0] IDX_RAW   = 3'd4;
  localparam logic [2:0] IDX_MASK  = 3'd5;

  localparam int CTRL_W = 7;

  // bit 6..5 psel, 4 wide, 3 ie, 2 oneshot, 1 periodic, 0 en
  typedef struct packed {
    logic [1:0] psel;
    logic       wide;
    logic       ie;
    logic       oneshot;
    logic       periodic;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/dtimer_presc.sv
module dtimer_presc #(
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);
  localparam int PRE_W = HI_LOG;
  localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << MID_LOG) - 1);
  localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << HI_LOG) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    case (psel)
      2'b01:   limit = LIM_MID;
      2'b10:   limit = LIM_HI;
      default: limit = '0;
    endcase
  end

  assign tick = run && (pre_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) pre_q <= '0;
    else                                pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/dtimer_core.sv
module dtimer_core
  import dtimer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] load_q,
  input  logic              load_wr,
  input  logic              val_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_q,
  output logic              raw_q,
  output logic              raw_d
);
  localparam logic [DATA_W-1:0] FULL   = '1;
  localparam logic [DATA_W-1:0] NARROW = DATA_W'((64'd1 << NARROW_W) - 64'd1);
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] count_d;
  logic              any_wr;
  logic              hit;

  assign mask   = ctrl.wide ? FULL : NARROW;
  assign any_wr = load_wr || val_wr;
  assign hit    = tick && !any_wr && (count_q == ONE);

  always_comb begin
    count_d = count_q;
    if (any_wr) begin
      count_d = wdata & mask;
    end else if (tick) begin
      if (count_q == '0) begin
        if (ctrl.oneshot)       count_d = '0;
        else if (ctrl.periodic) count_d = load_q & mask;
        else                    count_d = mask;
      end else begin
        count_d = count_q - ONE;
      end
    end
  end

  assign raw_d = hit ? 1'b1 : (clr_wr ? 1'b0 : raw_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      raw_q   <= raw_d;
    end
  end
endmodule

// File: rtl/dtimer_regs.sv
module dtimer_regs
  import dtimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [DATA_W-1:0] count,
  input  logic              raw,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_d,
  output logic [DATA_W-1:0] load_q,
  output logic              load_wr,
  output logic              val_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_d;

  assign idx     = addr[ADDR_W-1:2];
  assign load_wr = we && (idx == IDX_W'(IDX_LOAD));
  assign val_wr  = we && (idx == IDX_W'(IDX_VALUE));
  assign clr_wr  = we && (idx == IDX_W'(IDX_CLEAR));
  assign ctrl_d  = (we && (idx == IDX_W'(IDX_CTRL))) ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;

  always_comb begin
    rd_d = '0;
    case (idx)
      IDX_W'(IDX_LOAD):  rd_d = load_q;
      IDX_W'(IDX_VALUE): rd_d = count;
      IDX_W'(IDX_CTRL):  rd_d = DATA_W'(ctrl_q);
      IDX_W'(IDX_RAW):   rd_d = DATA_W'(raw);
      IDX_W'(IDX_MASK):  rd_d = DATA_W'(raw && ctrl_q.ie);
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      rdata  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (load_wr) load_q <= wdata;
      rdata <= rd_d;
    end
  end
endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
  import dtimer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int NARROW_W = 16,
  parameter int MID_LOG  = 4,
  parameter int HI_LOG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_d;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] count_q;
  logic              load_wr;
  logic              val_wr;
  logic              clr_wr;
  logic              raw_q;
  logic              raw_d;
  logic              tick;
  logic              irq_q;

  dtimer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .count(count_q), .raw(raw_q), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d),
    .load_q(load_q), .load_wr(load_wr), .val_wr(val_wr), .clr_wr(clr_wr),
    .rdata(bus_rdata)
  );

  dtimer_presc #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_presc (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .restart(load_wr || val_wr),
    .psel(ctrl_q.psel), .tick(tick)
  );

  dtimer_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl_q), .load_q(load_q),
    .load_wr(load_wr), .val_wr(val_wr), .clr_wr(clr_wr), .wdata(bus_wdata),
    .count_q(count_q), .raw_q(raw_q), .raw_d(raw_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= raw_d && ctrl_d.ie;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] count,
  input logic              raw,
  input logic              en,
  input logic              oneshot,
  input logic              ie,
  input logic              wide,
  input logic              load_wr,
  input logic              val_wr,
  input logic              clr_wr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] NARROW = DATA_W'((64'd1 << NARROW_W) - 64'd1);

  // R2
  load_imm_chk: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> count == ($past(wdata) & ($past(wide) ? {DATA_W{1'b1}} : NARROW)));

  // R12
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load_wr && !val_wr) |=> $stable(count));

  // R7
  oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
    (en && oneshot && count == '0 && !load_wr && !val_wr) |=> count == '0);

  // R8
  flag_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> count == '0);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && count != DATA_W'(1)) |=> !raw);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ie && raw));
endmodule

bind dtimer_top dtimer_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .count(count_q), .raw(raw_q), .en(ctrl_q.en),
  .oneshot(ctrl_q.oneshot), .ie(ctrl_q.ie), .wide(ctrl_q.wide),
  .load_wr(load_wr), .val_wr(val_wr), .clr_wr(clr_wr), .wdata(bus_wdata),
  .irq_o(irq_o)
);

// File: tb/tb_dtimer_top.sv
module tb_dtimer_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [4:0] A_LOAD = 5'h00, A_VAL = 5'h04, A_CTRL = 5'h08,
                         A_CLR = 5'h0C, A_RAW = 5'h10, A_MSK = 5'h14;
  localparam logic [31:0] EN = 32'h1, PER = 32'h2, ONE = 32'h4, IE = 32'h8, WIDE = 32'h10;

  // prescaler table: select, load, idle cycles m (run = m+1 edges), expected count
  localparam int NV = 6;
  localparam logic [1:0]  T_PSEL [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3};
  localparam logic [31:0] T_LOAD [NV] = '{32'd100, 32'd1000, 32'd1000, 32'd5000, 32'd5000, 32'd50};
  localparam int          T_IDLE [NV] = '{9, 159, 30, 511, 254, 4};
  localparam logic [31:0] T_EXP  [NV] = '{32'd90, 32'd990, 32'd999, 32'd4998, 32'd5000, 32'd45};

  dtimer_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(A_LOAD, v); chk("R1 load", v, 32'h0);
    rd(A_VAL, v);  chk("R1 value", v, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_RAW, v);  chk("R1 raw", v, 32'h0);

    // R2 / R3 preset paths
    wr(A_CTRL, WIDE);
    wr(A_LOAD, 32'hCAFE1234);
    rd(A_VAL, v);  chk("R2 value after load", v, 32'hCAFE1234);
    rd(A_LOAD, v); chk("R2 load readback", v, 32'hCAFE1234);
    wr(A_VAL, 32'h00000055);
    rd(A_VAL, v);  chk("R3 value direct", v, 32'h00000055);
    rd(A_LOAD, v); chk("R3 load untouched", v, 32'hCAFE1234);

    // R4 prescaler table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c;
      c = WIDE | (32'(T_PSEL[i]) << 5);
      wr(A_CTRL, c);
      wr(A_LOAD, T_LOAD[i]);
      wr(A_CTRL, c | EN);
      idle(T_IDLE[i]);
      wr(A_CTRL, c);
      rd(A_VAL, v);
      chk($sformatf("R4 prescale vector %0d", i), v, T_EXP[i]);
    end

    // R12 disabled holds
    wr(A_CTRL, WIDE);
    wr(A_LOAD, 32'd77);
    idle(20);
    rd(A_VAL, v); chk("R12 hold while disabled", v, 32'd77);

    // R5 free-running wrap, R8 flag
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, WIDE | EN);
    idle(2);
    wr(A_CTRL, WIDE);
    rd(A_VAL, v); chk("R5 wrap to all ones", v, 32'hFFFFFFFF);
    rd(A_RAW, v); chk("R8 raw set at zero", v, 32'h1);
    chk("R10 irq masked off", {31'b0, irq_o}, 32'h0);
    rd(A_MSK, v); chk("R10 masked status off", v, 32'h0);

    // R9 clear
    wr(A_CLR, 32'h0);
    rd(A_RAW, v); chk("R9 clear", v, 32'h0);

    // R6 periodic reload
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, WIDE | PER | EN);
    idle(4);
    wr(A_CTRL, WIDE);
    rd(A_VAL, v); chk("R6 reload then count", v, 32'd2);
    rd(A_LOAD, v); chk("R6 load kept", v, 32'd3);

    // R9 set beats clear on the same edge
    wr(A_CLR, 32'h0);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, WIDE | PER | EN);
    wr(A_CLR, 32'hFFFFFFFF);
    wr(A_CTRL, WIDE);
    rd(A_RAW, v); chk("R9 set wins over clear", v, 32'h1);
    wr(A_CLR, 32'h0);
    rd(A_RAW, v); chk("R9 clear after", v, 32'h0);

    // R10 interrupt gating
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, WIDE | PER | IE | EN);
    chk("R10 irq before zero", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 irq at zero", {31'b0, irq_o}, 32'h1);
    wr(A_CTRL, WIDE | IE);
    rd(A_MSK, v); chk("R10 masked status on", v, 32'h1);
    wr(A_CTRL, WIDE);
    chk("R10 irq gated off", {31'b0, irq_o}, 32'h0);
    rd(A_RAW, v); chk("R10 raw still set", v, 32'h1);

    // R11 narrow counter
    wr(A_CLR, 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'h00012345);
    rd(A_VAL, v); chk("R11 narrow mask", v, 32'h00002345);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, EN);
    idle(1);
    wr(A_CTRL, 32'h0);
    rd(A_VAL, v); chk("R11 narrow wrap", v, 32'h0000FFFF);

    // R7 one-shot, precedence over periodic, restart by load
    wr(A_CTRL, WIDE);
    wr(A_CLR, 32'h0);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, WIDE | ONE | PER | EN);
    idle(9);
    rd(A_VAL, v); chk("R7 parked at zero", v, 32'h0);
    rd(A_RAW, v); chk("R7 raw after single run", v, 32'h1);
    wr(A_CLR, 32'h0);
    wr(A_LOAD, 32'd2);
    rd(A_VAL, v); chk("R7 restart by load", v, 32'd2);
    idle(4);
    rd(A_VAL, v); chk("R7 parked again", v, 32'h0);
    rd(A_RAW, v); chk("R7 raw again", v, 32'h1);
    wr(A_CTRL, WIDE);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule